// File: doc/BRIEF.md
# Standby On-Demand Clock Request Controller

This block decides which clock sources and generic clock generators run while the chip sits in its low-power standby state. Every source carries a run-in-standby bit and an on-demand bit. Together they put the source in one of three standby behaviours: held off, kept running, or started only while something downstream asks for it. Every generator carries its own enable and run-in-standby bit. Two static selection inputs set the routing: which source feeds each generator, and which generator serves each peripheral.

Peripherals raise two kinds of request. An asynchronous clock request wakes that peripheral's own generator. A synchronous bus clock request wakes generator 0 and the main clock. Each woken generator then places a demand on the source it is routed to. A source takes a fixed number of cycles to become ready after it is switched on. A generator passes its clock only while its source is ready. When a bus clock is woken in standby, only the peripherals that requested it get an open bus gate; the rest stay gated at the main clock output. Outside standby, every enabled source and generator runs.

Top module: `stby_clk_ctrl`

## Requirements
- R1: While reset is asserted, all outputs are 0, whatever the inputs.
- R2: Outside standby, a source runs one cycle after its enable is 1, regardless of its mode bits. A disabled source never runs.
- R3: In standby, an enabled source follows its bits {run-in-standby, on-demand}. 1 on the on-demand bit: it runs on demand. 0/0: it is stopped. run-in-standby 1 with on-demand 0: it always runs.
- R4: A generator is active when it is enabled and at least one of these holds: standby is low, its run-in-standby bit is 1, or it is requested. A peripheral's asynchronous request targets generator `per_gen_sel_i[p]`. Any bus clock request targets generator 0.
- R5: An on-demand source in standby has demand when any active generator has `gen_src_sel_i[g]` equal to its index. Its run output rises one cycle after demand appears and falls one cycle after the last demand is withdrawn.
- R6: `src_ready_o[s]` goes to 1 exactly SU_CYC cycles after `src_run_o[s]` rises. It is 0 whenever `src_run_o[s]` is 0.
- R7: `gen_clk_en_o[g]` equals the generator's active state ANDed with the ready flag of its selected source.
- R8: `mclk_en_o` equals `gen_clk_en_o[0]` while standby is low. In standby it equals `gen_clk_en_o[0]` only while some bus request is 1, and is 0 otherwise.
- R9: Outside standby, every `bus_clk_en_o[p]` equals `mclk_en_o`. In standby, only peripherals with a bus request get `mclk_en_o`; every other bus gate is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Chip is in standby |
| src_en_i | input | NS | Per-source enable |
| src_runstby_i | input | NS | Per-source run-in-standby bit |
| src_ondemand_i | input | NS | Per-source on-demand bit |
| gen_en_i | input | NG | Per-generator enable |
| gen_runstby_i | input | NG | Per-generator run-in-standby bit |
| gen_src_sel_i | input | NG*SW | Source index feeding each generator |
| per_gen_sel_i | input | NP*GW | Generator index serving each peripheral |
| per_gclk_req_i | input | NP | Asynchronous generic clock request |
| per_bus_req_i | input | NP | Synchronous bus clock request |
| src_run_o | output | NS | Source switched on |
| src_ready_o | output | NS | Source has finished start-up |
| gen_clk_en_o | output | NG | Generator clock passes |
| mclk_en_o | output | 1 | Main clock enable |
| bus_clk_en_o | output | NP | Per-peripheral bus clock gate |

## Verification
The bench builds the block with two sources, two generators, two peripherals and a start-up delay of 3 cycles. The select fields are then one bit wide, so the sweep covers every routing of generators to sources. All 8192 combinations of standby, source enables, source mode bits, generator enables, generator run-in-standby bits and routing are walked. Random request and peripheral routing patterns are applied, each held for several cycles. That reaches source start-up, mid-start-up withdrawal, one-cycle off gaps, and bus-only wakes in which generator 0 and one source are pulled up through the chain.

// File: rtl/stby_clk_pkg.sv
package stby_clk_pkg;
  typedef enum logic [1:0] {
    SM_STOP   = 2'd0,
    SM_ALWAYS = 2'd1,
    SM_DEMAND = 2'd2
  } src_mode_e;

  function automatic src_mode_e stby_mode(input logic runstby, input logic ondemand);
    if (ondemand) return SM_DEMAND;
    if (runstby)  return SM_ALWAYS;
    return SM_STOP;
  endfunction
endpackage

// File: rtl/stby_demand_net.sv
module stby_demand_net #(
  parameter int NS = 4,
  parameter int NG = 4,
  parameter int NP = 8,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          standby_i,
  input  logic [NG-1:0] gen_en_i,
  input  logic [NG-1:0] gen_runstby_i,
  input  logic [NG*SW-1:0] gen_src_sel_i,
  input  logic [NP*GW-1:0] per_gen_sel_i,
  input  logic [NP-1:0] per_gclk_req_i,
  input  logic [NP-1:0] per_bus_req_i,
  output logic [NG-1:0] gen_act_o,
  output logic [NS-1:0] src_dem_o
);
  logic [NG-1:0] gen_req;

  always_comb begin
    gen_req = '0;
    for (int g = 0; g < NG; g++) begin
      for (int p = 0; p < NP; p++) begin
        if (per_gclk_req_i[p] && per_gen_sel_i[p*GW +: GW] == GW'(g)) gen_req[g] = 1'b1;
      end
    end
    if (|per_bus_req_i) gen_req[0] = 1'b1;
  end

  always_comb begin
    for (int g = 0; g < NG; g++)
      gen_act_o[g] = gen_en_i[g] & (~standby_i | gen_runstby_i[g] | gen_req[g]);
  end

  always_comb begin
    src_dem_o = '0;
    for (int s = 0; s < NS; s++) begin
      for (int g = 0; g < NG; g++) begin
        if (gen_act_o[g] && gen_src_sel_i[g*SW +: SW] == SW'(s)) src_dem_o[s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/stby_src_slot.sv
module stby_src_slot
  import stby_clk_pkg::*;
#(
  parameter int SU_CYC = 4,
  localparam int CW = $clog2(SU_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic en_i,
  input  logic runstby_i,
  input  logic ondemand_i,
  input  logic demand_i,
  output logic run_o,
  output logic ready_o
);
  src_mode_e mode;
  logic      stby_on;
  logic      on;
  logic [CW-1:0] cnt_q;

  assign mode = stby_mode(runstby_i, ondemand_i);

  always_comb begin
    case (mode)
      SM_ALWAYS: stby_on = 1'b1;
      SM_DEMAND: stby_on = demand_i;
      default:   stby_on = 1'b0;
    endcase
  end

  assign on = en_i & (standby_i ? stby_on : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_o <= on;
      if (!run_o)                    cnt_q <= '0;
      else if (cnt_q < CW'(SU_CYC))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = run_o & (cnt_q == CW'(SU_CYC));

  generate
    if (SU_CYC > 0) begin : g_su_chk
      a_r6_ready_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(run_o));
    end
  endgenerate

  a_r5_off_after_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_i && ondemand_i && !demand_i) |=> !run_o);
endmodule

// File: rtl/stby_clk_ctrl.sv
module stby_clk_ctrl #(
  parameter int NS = 4,
  parameter int NG = 4,
  parameter int NP = 8,
  parameter int SU_CYC = 4,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic [NS-1:0]    src_en_i,
  input  logic [NS-1:0]    src_runstby_i,
  input  logic [NS-1:0]    src_ondemand_i,
  input  logic [NG-1:0]    gen_en_i,
  input  logic [NG-1:0]    gen_runstby_i,
  input  logic [NG*SW-1:0] gen_src_sel_i,
  input  logic [NP*GW-1:0] per_gen_sel_i,
  input  logic [NP-1:0]    per_gclk_req_i,
  input  logic [NP-1:0]    per_bus_req_i,
  output logic [NS-1:0]    src_run_o,
  output logic [NS-1:0]    src_ready_o,
  output logic [NG-1:0]    gen_clk_en_o,
  output logic             mclk_en_o,
  output logic [NP-1:0]    bus_clk_en_o
);
  logic [NG-1:0] gen_act;
  logic [NS-1:0] src_dem;

  stby_demand_net #(.NS(NS), .NG(NG), .NP(NP)) u_net (
    .standby_i      (standby_i),
    .gen_en_i       (gen_en_i),
    .gen_runstby_i  (gen_runstby_i),
    .gen_src_sel_i  (gen_src_sel_i),
    .per_gen_sel_i  (per_gen_sel_i),
    .per_gclk_req_i (per_gclk_req_i),
    .per_bus_req_i  (per_bus_req_i),
    .gen_act_o      (gen_act),
    .src_dem_o      (src_dem)
  );

  for (genvar s = 0; s < NS; s++) begin : g_src
    stby_src_slot #(.SU_CYC(SU_CYC)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .standby_i  (standby_i),
      .en_i       (src_en_i[s]),
      .runstby_i  (src_runstby_i[s]),
      .ondemand_i (src_ondemand_i[s]),
      .demand_i   (src_dem[s]),
      .run_o      (src_run_o[s]),
      .ready_o    (src_ready_o[s])
    );

    a_r2_awake_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby_i && src_en_i[s]) |=> src_run_o[s]);
    a_r3_stopped_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_i && !src_runstby_i[s] && !src_ondemand_i[s]) |=> !src_run_o[s]);
  end

  always_comb begin
    gen_clk_en_o = '0;
    for (int g = 0; g < NG; g++) begin
      for (int s = 0; s < NS; s++) begin
        if (gen_src_sel_i[g*SW +: SW] == SW'(s))
          gen_clk_en_o[g] = gen_act[g] & src_ready_o[s];
      end
    end
  end

  assign mclk_en_o = gen_clk_en_o[0] & (~standby_i | (|per_bus_req_i));

  for (genvar p = 0; p < NP; p++) begin : g_bus
    assign bus_clk_en_o[p] = mclk_en_o & (~standby_i | per_bus_req_i[p]);

    a_r9_only_requester: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_i && bus_clk_en_o[p]) |-> per_bus_req_i[p]);
  end

  for (genvar g = 0; g < NG; g++) begin : g_gchk
    for (genvar s = 0; s < NS; s++) begin : g_s
      a_r7_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_clk_en_o[g] && gen_src_sel_i[g*SW +: SW] == SW'(s)) |-> src_ready_o[s]);
    end
  end

  a_r8_mclk_needs_gen0: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en_o |-> gen_clk_en_o[0]);
endmodule

// File: tb/stby_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module stby_clk_ctrl_tb_top;
  localparam int NS = 2, NG = 2, NP = 2, SU = 3;
  localparam int SW = 1, GW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby;
  logic [NS-1:0] s_en, s_rs, s_od;
  logic [NG-1:0] g_en, g_rs;
  logic [NG*SW-1:0] g_sel;
  logic [NP*GW-1:0] p_sel;
  logic [NP-1:0] p_greq, p_breq;
  logic [NS-1:0] run, rdy;
  logic [NG-1:0] gclk;
  logic mclk;
  logic [NP-1:0] bus;

  int checks = 0, fails = 0;
  int m_run [NS];
  int m_cnt [NS];

  always #4 clk = ~clk;

  stby_clk_ctrl #(.NS(NS), .NG(NG), .NP(NP), .SU_CYC(SU)) dut_i (
    .clk(clk), .rst_n(rst_n), .standby_i(standby),
    .src_en_i(s_en), .src_runstby_i(s_rs), .src_ondemand_i(s_od),
    .gen_en_i(g_en), .gen_runstby_i(g_rs), .gen_src_sel_i(g_sel),
    .per_gen_sel_i(p_sel), .per_gclk_req_i(p_greq), .per_bus_req_i(p_breq),
    .src_run_o(run), .src_ready_o(rdy), .gen_clk_en_o(gclk),
    .mclk_en_o(mclk), .bus_clk_en_o(bus)
  );

  function automatic logic e_gen_act(int g);
    logic req = 1'b0;
    for (int p = 0; p < NP; p++) if (p_greq[p] && p_sel[p] == g[0]) req = 1'b1;
    if (g == 0 && p_breq != 0) req = 1'b1;
    return g_en[g] && (!standby || g_rs[g] || req);
  endfunction

  function automatic logic e_src_on(int s);
    logic dem = 1'b0;
    for (int g = 0; g < NG; g++) if (e_gen_act(g) && g_sel[g] == s[0]) dem = 1'b1;
    if (!s_en[s]) return 1'b0;
    if (!standby) return 1'b1;
    if (s_od[s]) return dem;
    return s_rs[s];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin m_run[s] = 0; m_cnt[s] = 0; end
    end else begin
      for (int s = 0; s < NS; s++) begin
        m_cnt[s] = (m_run[s] == 0) ? 0 : ((m_cnt[s] < SU) ? m_cnt[s] + 1 : m_cnt[s]);
        m_run[s] = e_src_on(s) ? 1 : 0;
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [NS-1:0] er;
    logic [NG-1:0] eg;
    logic em;
    for (int s = 0; s < NS; s++) begin
      chk(standby ? "R3 R5 src_run" : "R2 src_run", run[s], m_run[s] != 0);
      er[s] = (m_run[s] != 0) && (m_cnt[s] == SU);
      chk("R6 src_ready", rdy[s], er[s]);
    end
    for (int g = 0; g < NG; g++) begin
      eg[g] = e_gen_act(g) && er[g_sel[g]];
      chk("R4 R7 gen_clk_en", gclk[g], eg[g]);
    end
    em = eg[0] && (!standby || p_breq != 0);
    chk("R8 mclk_en", mclk, em);
    for (int p = 0; p < NP; p++)
      chk("R9 bus_clk_en", bus[p], em && (!standby || p_breq[p]));
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    standby = 1'b1; s_en = '1; s_rs = '1; s_od = '0; g_en = '1; g_rs = '1;
    g_sel = '0; p_sel = '0; p_greq = '1; p_breq = '1;
    repeat (3) @(negedge clk);
    // R1: outputs held low under reset with active inputs
    chk("R1 run", run != 0, 1'b0);
    chk("R1 ready", rdy != 0, 1'b0);
    chk("R1 gen", gclk != 0, 1'b0);
    chk("R1 mclk", mclk, 1'b0);
    chk("R1 bus", bus != 0, 1'b0);
    rst_n = 1'b1;
    for (int c = 0; c < 8192; c++) begin
      @(negedge clk);
      standby = c[12];
      s_en = c[1:0];
      s_od = c[3:2];
      s_rs = c[5:4];
      g_sel = c[7:6];
      g_en = c[9:8];
      g_rs = c[11:10];
      p_sel = NP'($urandom);
      p_greq = NP'($urandom);
      p_breq = NP'($urandom);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check_all();
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule